// File: doc/BRIEF.md
# Refresh-Triggered Memory Bank Mapper

This block decides which memory device answers in each 32 KB half of a 64 KB processor address space. After reset a boot FLASH occupies the lower half and SRAM bank 0 the upper half. Software copies the boot image into RAM and then flips the spare top bit of the processor's refresh counter. That bit is seen on address line 7 during refresh bus cycles. The map then switches to RAM-only operation: SRAM bank 0 goes low, and SRAM bank 1 or bank 2 goes high. The FLASH cannot come back until the next reset.

The map is only updated at the close of a refresh cycle. By then the processor has already fetched the following opcode from the old map, so software can flip the bit and continue executing without a jump. The logic runs on a system clock that samples the bus strobes, and it finds the end of a refresh cycle by watching the strobe levels from one clock to the next. The current map is also driven out as a 2-bit code.

Top module: `refresh_bank_mapper`

## Requirements
- R1: After reset the map code is 00 (bit 1 = lock bit, bit 0 = follow bit). A lower-half access (`a_hi`=0) selects the boot FLASH, and an upper-half access selects SRAM bank 0.
- R2: A chip select is active (low) only while `mreq_n` is 0 and `rfsh_n` is 1. During refresh and when the bus is idle, all selects are high.
- R3: At most one of `cs_boot_n`, `cs_sram_n[2:0]` is low in any cycle.
- R4: `a_hi` chooses the half. With map 11 the lower half is SRAM bank 0 (`cs_sram_n[0]`) and the upper half is SRAM bank 1 (`cs_sram_n[1]`). With map 10 the lower half is bank 0 and the upper half is bank 2 (`cs_sram_n[2]`).
- R5: The map changes only in the clock after the first rising edge that samples both `mreq_n` and `rfsh_n` high following a qualifying refresh cycle. At every other edge it holds.
- R6: A refresh cycle qualifies only if `mreq_n` goes from 1 to 0 while `rfsh_n` is already 0. If `rfsh_n` falls after `mreq_n` is already low, the map does not change.
- R7: In map 00, a qualifying refresh with `a_ref`=0 leaves the map at 00.
- R8: A qualifying refresh with `a_ref`=1 sets the map to 11 from any map.
- R9: Once the lock bit is set, each qualifying refresh copies `a_ref` into the follow bit, so the map moves between 10 and 11. Map 00 is never reached again before reset, and map 01 never occurs.
- R10: `map_state` shows the current map code in every cycle.
- R11: The `a_ref` value used is the last one sampled while both strobes were low during the qualifying cycle. The value of `a_ref` outside refresh cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_n | input | 1 | Memory request strobe, active low |
| rfsh_n | input | 1 | Refresh cycle strobe, active low |
| a_hi | input | 1 | Address bit 15: 0 = lower half, 1 = upper half |
| a_ref | input | 1 | Address bit 7: carries the spare refresh-counter bit during refresh |
| cs_boot_n | output | 1 | Boot FLASH select, active low |
| cs_sram_n | output | 3 | SRAM bank selects, bit i = bank i, active low |
| map_state | output | 2 | Current map code {lock, follow} |

## Verification
The bench goes after the strobe ordering. If `rfsh_n` falls after `mreq_n`, a design that treats any overlap of the two strobes as a refresh would wrongly switch away from the FLASH. The bench also changes `a_ref` in the middle of a refresh and during normal accesses. A design that latches too early, or that samples outside refresh, would then land on the wrong bank. The bench checks that 00 never returns after the lock bit is set, and that selects stay off during refresh. A design that fails the first would bring the FLASH back into a RAM-only map. A design that fails the second would drive a device onto the bus while the refresh address is out. A behavioural model is compared against the design every clock, so a map update one cycle early or late is caught immediately.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int SRAM_BANKS = 3;
  localparam int MAP_W      = 2;

  typedef struct packed {
    logic lock;
    logic follow;
  } map_code_t;

  typedef enum logic [2:0] {
    DEV_NONE  = 3'd0,
    DEV_BOOT  = 3'd1,
    DEV_SRAM0 = 3'd2,
    DEV_SRAM1 = 3'd3,
    DEV_SRAM2 = 3'd4
  } dev_sel_t;
endpackage

// File: rtl/rbm_refresh_tracker.sv
module rbm_refresh_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic mreq_n,
  input  logic rfsh_n,
  input  logic a_ref,
  output logic cycle_done,
  output logic ref_bit
);
  logic mreq_q;
  logic armed;
  logic start_hit;
  logic both_low;

  // Qualifying start: request strobe falls while refresh strobe is already low
  assign start_hit  = mreq_q & ~mreq_n & ~rfsh_n;
  assign both_low   = ~mreq_n & ~rfsh_n;
  assign cycle_done = armed & mreq_n & rfsh_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mreq_q  <= 1'b1;
      armed   <= 1'b0;
      ref_bit <= 1'b0;
    end else begin
      mreq_q <= mreq_n;
      if (start_hit)
        armed <= 1'b1;
      else if (cycle_done)
        armed <= 1'b0;
      if (start_hit || (armed && both_low))
        ref_bit <= a_ref;
    end
  end
endmodule

// File: rtl/rbm_map_state.sv
module rbm_map_state
  import rbm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      advance,
  input  logic      ref_bit,
  output map_code_t code
);
  logic lock_nxt;

  // Lock bit is set-only; follow bit tracks the refresh bit but is held clear while unlocked
  assign lock_nxt = code.lock | ref_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (advance) begin
      code.lock   <= lock_nxt;
      code.follow <= lock_nxt & ref_bit;
    end
  end
endmodule

// File: rtl/rbm_cs_decode.sv
module rbm_cs_decode
  import rbm_pkg::*;
(
  input  map_code_t              code,
  input  logic                   mreq_n,
  input  logic                   rfsh_n,
  input  logic                   a_hi,
  output logic                   cs_boot_n,
  output logic [SRAM_BANKS-1:0]  cs_sram_n
);
  dev_sel_t pick;
  logic     access;

  assign access = ~mreq_n & rfsh_n;

  always_comb begin
    pick = DEV_NONE;
    if (access) begin
      if (!a_hi)
        pick = code.lock ? DEV_SRAM0 : DEV_BOOT;
      else if (!code.lock)
        pick = DEV_SRAM0;
      else
        pick = code.follow ? DEV_SRAM1 : DEV_SRAM2;
    end
  end

  assign cs_boot_n = (pick != DEV_BOOT);

  for (genvar b = 0; b < SRAM_BANKS; b++) begin : g_bank
    assign cs_sram_n[b] = (pick != dev_sel_t'(int'(DEV_SRAM0) + b));
  end
endmodule

// File: rtl/refresh_bank_mapper.sv
module refresh_bank_mapper
  import rbm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mreq_n,
  input  logic                  rfsh_n,
  input  logic                  a_hi,
  input  logic                  a_ref,
  output logic                  cs_boot_n,
  output logic [SRAM_BANKS-1:0] cs_sram_n,
  output logic [MAP_W-1:0]      map_state
);
  logic      cycle_done;
  logic      ref_bit;
  map_code_t code;

  rbm_refresh_tracker i_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mreq_n     (mreq_n),
    .rfsh_n     (rfsh_n),
    .a_ref      (a_ref),
    .cycle_done (cycle_done),
    .ref_bit    (ref_bit)
  );

  rbm_map_state i_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (cycle_done),
    .ref_bit (ref_bit),
    .code    (code)
  );

  rbm_cs_decode i_dec (
    .code      (code),
    .mreq_n    (mreq_n),
    .rfsh_n    (rfsh_n),
    .a_hi      (a_hi),
    .cs_boot_n (cs_boot_n),
    .cs_sram_n (cs_sram_n)
  );

  assign map_state = code;
endmodule

// File: rtl/rbm_checker.sv
module rbm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mreq_n,
  input logic       rfsh_n,
  input logic       a_hi,
  input logic       cs_boot_n,
  input logic [2:0] cs_sram_n,
  input logic [1:0] map_state
);
  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~cs_boot_n, ~cs_sram_n}) <= 1); // R3

  AST_QUIET_OUTSIDE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mreq_n && rfsh_n) |-> (cs_boot_n && (&cs_sram_n))); // R2

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    map_state[1] |=> map_state[1]); // R9

  AST_NO_MAP_01: assert property (@(posedge clk) disable iff (!rst_n)
    map_state != 2'b01); // R9

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n || !rfsh_n) |=> $stable(map_state)); // R5

  AST_BOOT_ONLY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_boot_n |-> (map_state == 2'b00 && !a_hi)); // R4
endmodule

bind refresh_bank_mapper rbm_checker i_rbm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .mreq_n    (mreq_n),
  .rfsh_n    (rfsh_n),
  .a_hi      (a_hi),
  .cs_boot_n (cs_boot_n),
  .cs_sram_n (cs_sram_n),
  .map_state (map_state)
);

// File: tb/test_refresh_bank_mapper.sv
`timescale 1ns/100ps
module test_refresh_bank_mapper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mreq_n = 1'b1;
  logic       rfsh_n = 1'b1;
  logic       a_hi = 1'b0;
  logic       a_ref = 1'b0;
  logic       cs_boot_n;
  logic [2:0] cs_sram_n;
  logic [1:0] map_state;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  int m_lock = 0, m_fol = 0, m_prev_mreq = 1, m_armed = 0, m_bit = 0;

  always #2.5 clk = ~clk;

  refresh_bank_mapper i_refresh_bank_mapper (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .rfsh_n(rfsh_n),
    .a_hi(a_hi), .a_ref(a_ref), .cs_boot_n(cs_boot_n),
    .cs_sram_n(cs_sram_n), .map_state(map_state)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock = 0; m_fol = 0; m_prev_mreq = 1; m_armed = 0; m_bit = 0;
    end else begin
      int strt;
      strt = (m_prev_mreq == 1 && mreq_n == 0 && rfsh_n == 0);
      if (m_armed && mreq_n && rfsh_n) begin
        if (m_bit) m_lock = 1;
        m_fol = m_lock ? m_bit : 0;
        m_armed = 0;
      end
      if (strt || (m_armed && !mreq_n && !rfsh_n)) m_bit = a_ref;
      if (strt) m_armed = 1;
      m_prev_mreq = mreq_n;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_cs;
      exp_cs = 4'b1111;
      if (!mreq_n && rfsh_n) begin
        if (!a_hi) exp_cs = m_lock ? 4'b1110 : 4'b0111;
        else if (!m_lock) exp_cs = 4'b1110;
        else exp_cs = m_fol ? 4'b1101 : 4'b1011;
      end
      chk((!mreq_n && rfsh_n) ? "R4 selects" : "R2 selects", {cs_boot_n, cs_sram_n}, exp_cs);
      chk("R10 R5 map_state", map_state, m_lock * 2 + m_fol);
      chk("R3 one select", ($countones({~cs_boot_n, ~cs_sram_n}) <= 1), 1);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic access(bit hi, bit refv);
    a_hi = hi; a_ref = refv; mreq_n = 0; rfsh_n = 1;
    step(2);
    mreq_n = 1;
    step(1);
  endtask

  // good_order: refresh strobe first, then request strobe; mid lets a_ref change late
  task automatic refresh(bit good_order, bit v_start, bit v_end);
    a_ref = v_start;
    if (good_order) rfsh_n = 0; else mreq_n = 0;
    step(1);
    if (good_order) mreq_n = 0; else rfsh_n = 0;
    step(1);
    a_ref = v_end;
    step(1);
    mreq_n = 1; rfsh_n = 1; a_ref = 0;
    step(2);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 reset map", map_state, 0);
    a_hi = 0; mreq_n = 0; step(1);
    chk("R1 boot low", cs_boot_n, 0);
    mreq_n = 1; step(1);
    access(1, 0);
    refresh(1, 0, 0);
    chk("R7 a_ref 0 keeps 00", map_state, 0);
    refresh(0, 1, 1);
    chk("R6 wrong strobe order", map_state, 0);
    access(0, 1); access(1, 1);
    chk("R11 a_ref outside refresh", map_state, 0);
    refresh(1, 1, 1);
    chk("R8 set to 11", map_state, 3);
    a_hi = 1; mreq_n = 0; step(1);
    chk("R4 upper bank1", cs_sram_n, 3'b101);
    mreq_n = 1; step(1);
    access(0, 0);
    refresh(1, 0, 0);
    chk("R9 move to 10", map_state, 2);
    a_hi = 1; mreq_n = 0; step(1);
    chk("R4 upper bank2", cs_sram_n, 3'b011);
    mreq_n = 1; step(1);
    refresh(1, 0, 1);
    chk("R11 late a_ref wins", map_state, 3);
    refresh(1, 1, 0);
    chk("R11 late a_ref 0", map_state, 2);
    refresh(1, 0, 0);
    chk("R9 no return to 00", map_state, 2);
    rfsh_n = 0; a_hi = 0; step(1);
    chk("R2 idle refresh no select", {cs_boot_n, cs_sram_n}, 4'b1111);
    rfsh_n = 1; step(1);
    rst_n = 0; step(2); rst_n = 1; step(1);
    chk("R1 reset again", map_state, 0);
    access(0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule